// File: doc/BRIEF.md
# Prefetching Fetch-Execute Sequencer

This block is the hard-wired control unit of a small stored-program processor. It owns the program counter and the instruction register and drives the address of the instruction memory read port. The memory returns the addressed word on the same cycle, and the instruction register captures that word on the next clock edge. Each cycle the current instruction word and the sequencer state are decoded combinationally into datapath strobes. Fetch overlaps execute: the word after the current instruction is always being read while the current instruction runs, and reset already loads the first word, so execution starts on the first cycle after reset.

Branches are relative to the program counter. The program counter then holds the address that follows the branch instruction, and the signed displacement is added to it. A taken branch costs one wait cycle. In that cycle the word that was being prefetched is dropped and the word at the target is fetched. Some opcodes hold the execute state for several cycles, counted down by an internal counter. A halt opcode freezes the sequencer until the next reset. A small stub datapath holds an 8-bit accumulator, and its zero and negative flags feed the conditional branches.

Instruction word: opcode in bits [15:12], operand select in [11:8], signed 8-bit displacement or immediate in [7:0].

Top module: `fetch_exec_ctrl`

## Requirements
- R1: While reset is high, the instruction register loads the word at START_ADDR, the program counter becomes START_ADDR+INCR, the accumulator clears to 0, and halted and in_wait are 0.
- R2: Outside reset, imem_addr equals pc_o. In the last execute cycle of any instruction that neither branches nor halts, the instruction register loads the word at pc_o and pc_o advances by INCR.
- R3: Opcode 4 (jump) always sets pc_o to pc_o plus the sign-extended bits [7:0]. Here pc_o is the address that follows the jump.
- R4: Opcode 5 branches when the zero flag (accumulator == 0) is set, and opcode 6 branches when the negative flag (accumulator bit 7) is set. A taken branch goes to the same target as R3. An untaken branch advances like R2.
- R5: A taken branch raises branch_taken and leaves the instruction register unchanged. The next cycle is a wait cycle (in_wait=1) that loads the word at the target and sets pc_o to target+INCR. The word at the fall-through address is never executed.
- R6: Opcode 2 runs for 3 execute cycles and opcode 3 for 4. pc_o and ir_o hold until the last of these cycles, and ctl_last is 1 only in the last one.
- R7: ctl_alu_en is 1 while opcode 1 executes, and ctl_shift_en is 1 in every execute cycle of opcode 2. Both strobes and branch_taken are 0 during wait and halt cycles.
- R8: Opcode 15 sets halted from the next cycle on. pc_o and ir_o then stay frozen until reset.
- R9: Opcode 1 adds the sign-extended bits [7:0] to the accumulator. Opcode 2 shifts the accumulator left by one bit in its last cycle.
- R10: Opcodes 0 and 7 to 14 run as single-cycle no-ops that advance as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | AW | Instruction memory read address |
| imem_rdata | input | 16 | Word at imem_addr |
| pc_o | output | AW | Program counter (next fetch address) |
| ir_o | output | 16 | Instruction register |
| halted | output | 1 | Sequencer stopped by halt opcode |
| in_wait | output | 1 | Branch wait cycle in progress |
| branch_taken | output | 1 | Current cycle redirects the PC |
| ctl_alu_en | output | 1 | Add-immediate strobe |
| ctl_shift_en | output | 1 | Shift strobe (all cycles of opcode 2) |
| ctl_last | output | 1 | Last execute cycle of the current instruction |
| ctl_sel | output | 4 | Operand select field, zero when not executing |
| acc_o | output | 8 | Stub datapath accumulator |
| flag_zero | output | 1 | Accumulator equals zero |
| flag_neg | output | 1 | Accumulator bit 7 |

## Verification
Every sequencer result is registered once. A PC, IR, accumulator or state change caused by the instruction in the IR shows on the ports one clock edge later. The strobes and branch_taken are combinational from the present IR and state, so they are valid in the same cycle. The bench drives inputs and compares outputs only on falling edges, so exactly one rising edge lies between checks. A cycle-stepped reference model, written from the requirements, advances once per falling edge and is compared right after its step. The multi-cycle holds and the one-cycle branch penalty therefore appear as exact per-cycle PC and IR values.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int IW    = 16;
    localparam int OPW   = 4;
    localparam int DW    = 8;
    localparam int CNT_W = 3;

    localparam logic [OPW-1:0] OP_NOP   = 4'd0;
    localparam logic [OPW-1:0] OP_ADDI  = 4'd1;
    localparam logic [OPW-1:0] OP_SHL   = 4'd2;
    localparam logic [OPW-1:0] OP_STALL = 4'd3;
    localparam logic [OPW-1:0] OP_JMP   = 4'd4;
    localparam logic [OPW-1:0] OP_BZ    = 4'd5;
    localparam logic [OPW-1:0] OP_BN    = 4'd6;
    localparam logic [OPW-1:0] OP_HALT  = 4'd15;

    typedef struct packed {
        logic [OPW-1:0] op;
        logic [3:0]     sel;
        logic [DW-1:0]  disp;
    } instr_t;

    typedef enum logic [1:0] {
        ST_EXEC = 2'd0,
        ST_WAIT = 2'd1,
        ST_HALT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic alu_en;
        logic shift_en;
        logic taken;
        logic halt_req;
    } ctrl_t;

    // execute cycles beyond the first, per opcode
    function automatic logic [CNT_W-1:0] extra_cycles(input logic [OPW-1:0] op);
        case (op)
            OP_SHL:   extra_cycles = CNT_W'(2);
            OP_STALL: extra_cycles = CNT_W'(3);
            default:  extra_cycles = '0;
        endcase
    endfunction

endpackage

// File: rtl/fx_decoder.sv
module fx_decoder
    import fetch_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic           exec,
    input  logic           last,
    input  logic           zf,
    input  logic           nf,
    output ctrl_t          ctrl
);
    logic cond_ok;

    always_comb begin
        case (op)
            OP_JMP:  cond_ok = 1'b1;
            OP_BZ:   cond_ok = zf;
            OP_BN:   cond_ok = nf;
            default: cond_ok = 1'b0;
        endcase
        ctrl.alu_en   = exec && (op == OP_ADDI);
        ctrl.shift_en = exec && (op == OP_SHL);
        ctrl.taken    = exec && last && cond_ok;
        ctrl.halt_req = exec && last && (op == OP_HALT);
    end
endmodule

// File: rtl/fx_sequencer.sv
module fx_sequencer
    import fetch_pkg::*;
#(
    parameter int             AW         = 10,
    parameter logic [AW-1:0]  START_ADDR = '0,
    parameter logic [AW-1:0]  INCR       = AW'(1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rdata,
    input  logic          take,
    input  logic          halt_req,
    output logic [AW-1:0] pc,
    output instr_t        ir,
    output seq_state_e    state,
    output logic          last
);
    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    target;
    instr_t           fetched;

    assign fetched = instr_t'(rdata);
    assign target  = pc + {{(AW-DW){ir.disp[DW-1]}}, ir.disp};
    assign last    = (state == ST_EXEC) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= START_ADDR + INCR;
            ir    <= fetched;
            cnt   <= extra_cycles(fetched.op);
            state <= ST_EXEC;
        end else begin
            case (state)
                ST_EXEC: begin
                    if (cnt != '0) begin
                        cnt <= cnt - CNT_W'(1);
                    end else if (halt_req) begin
                        state <= ST_HALT;
                    end else if (take) begin
                        pc    <= target;
                        state <= ST_WAIT;
                    end else begin
                        ir  <= fetched;
                        pc  <= pc + INCR;
                        cnt <= extra_cycles(fetched.op);
                    end
                end
                ST_WAIT: begin
                    ir    <= fetched;
                    pc    <= pc + INCR;
                    cnt   <= extra_cycles(fetched.op);
                    state <= ST_EXEC;
                end
                default: begin
                    state <= ST_HALT;
                end
            endcase
        end
    end
endmodule

// File: rtl/fx_stub_dp.sv
module fx_stub_dp
    import fetch_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          alu_en,
    input  logic          shift_en,
    input  logic          last,
    input  logic [DW-1:0] imm,
    output logic [7:0]    acc,
    output logic          zf,
    output logic          nf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (alu_en) begin
            acc <= acc + 8'(imm);
        end else if (shift_en && last) begin
            acc <= {acc[6:0], 1'b0};
        end
    end

    assign zf = (acc == 8'd0);
    assign nf = acc[7];
endmodule

// File: rtl/fetch_exec_ctrl.sv
module fetch_exec_ctrl
    import fetch_pkg::*;
#(
    parameter int             AW         = 10,
    parameter logic [AW-1:0]  START_ADDR = '0,
    parameter logic [AW-1:0]  INCR       = AW'(1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] imem_addr,
    input  logic [15:0]   imem_rdata,
    output logic [AW-1:0] pc_o,
    output logic [15:0]   ir_o,
    output logic          halted,
    output logic          in_wait,
    output logic          branch_taken,
    output logic          ctl_alu_en,
    output logic          ctl_shift_en,
    output logic          ctl_last,
    output logic [3:0]    ctl_sel,
    output logic [7:0]    acc_o,
    output logic          flag_zero,
    output logic          flag_neg
);
    logic [AW-1:0] pc;
    instr_t        ir;
    seq_state_e    state;
    logic          last;
    ctrl_t         ctrl;
    logic          zf, nf;
    logic          exec;

    assign exec = (state == ST_EXEC);

    fx_sequencer #(.AW(AW), .START_ADDR(START_ADDR), .INCR(INCR)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .rdata    (imem_rdata),
        .take     (ctrl.taken),
        .halt_req (ctrl.halt_req),
        .pc       (pc),
        .ir       (ir),
        .state    (state),
        .last     (last)
    );

    fx_decoder u_dec (
        .op   (ir.op),
        .exec (exec),
        .last (last),
        .zf   (zf),
        .nf   (nf),
        .ctrl (ctrl)
    );

    fx_stub_dp u_dp (
        .clk      (clk),
        .rst      (rst),
        .alu_en   (ctrl.alu_en),
        .shift_en (ctrl.shift_en),
        .last     (last),
        .imm      (ir.disp),
        .acc      (acc_o),
        .zf       (zf),
        .nf       (nf)
    );

    assign imem_addr    = rst ? START_ADDR : pc;
    assign pc_o         = pc;
    assign ir_o         = ir;
    assign halted       = (state == ST_HALT);
    assign in_wait      = (state == ST_WAIT);
    assign branch_taken = ctrl.taken;
    assign ctl_alu_en   = ctrl.alu_en;
    assign ctl_shift_en = ctrl.shift_en;
    assign ctl_last     = last;
    assign ctl_sel      = exec ? ir.sel : 4'd0;
    assign flag_zero    = zf;
    assign flag_neg     = nf;
endmodule

// File: rtl/fetch_exec_ctrl_chk.sv
module fetch_exec_ctrl_chk #(
    parameter int            AW   = 10,
    parameter logic [AW-1:0] INCR = AW'(1)
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] pc_o,
    input logic [15:0]   ir_o,
    input logic          halted,
    input logic          in_wait,
    input logic          branch_taken,
    input logic          ctl_alu_en,
    input logic          ctl_shift_en,
    input logic          ctl_last
);
    // R2
    alu_advance_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_alu_en |=> pc_o == $past(pc_o) + INCR);

    // R3
    branch_target_chk: assert property (@(posedge clk) disable iff (rst)
        branch_taken |=> pc_o == $past(pc_o) + {{(AW-8){$past(ir_o[7])}}, $past(ir_o[7:0])});

    // R5
    wait_follows_branch_chk: assert property (@(posedge clk) disable iff (rst)
        branch_taken |=> (in_wait && $stable(ir_o)));

    // R5
    wait_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        in_wait |=> (!in_wait && pc_o == $past(pc_o) + INCR));

    // R6
    multi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_shift_en && !ctl_last) |=> ($stable(pc_o) && $stable(ir_o)));

    // R7
    idle_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        (in_wait || halted) |-> (!ctl_alu_en && !ctl_shift_en && !branch_taken));

    // R8
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc_o) && $stable(ir_o)));
endmodule

bind fetch_exec_ctrl fetch_exec_ctrl_chk #(.AW(AW), .INCR(INCR)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pc_o         (pc_o),
    .ir_o         (ir_o),
    .halted       (halted),
    .in_wait      (in_wait),
    .branch_taken (branch_taken),
    .ctl_alu_en   (ctl_alu_en),
    .ctl_shift_en (ctl_shift_en),
    .ctl_last     (ctl_last)
);

// File: tb/fetch_exec_ctrl_tb.sv
module fetch_exec_ctrl_tb;
    localparam int            AW    = 10;
    localparam logic [AW-1:0] START = AW'(16);
    localparam int            NPROG = 20;

    // program placed at START: ADDI/SHL/branches/stall/no-op/halt mix
    localparam logic [15:0] PROG [NPROG] = '{
        16'h1001, 16'h2000, 16'h10FE, 16'h5002, 16'h1005,
        16'hF000, 16'h10FF, 16'h5005, 16'h6001, 16'h1007,
        16'h3000, 16'h4001, 16'h1009, 16'h9ABC, 16'h1001,
        16'h60F8, 16'h5002, 16'hF000, 16'hF000, 16'h40FE
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] imem_addr;
    logic [15:0]   imem_rdata;
    logic [AW-1:0] pc_o;
    logic [15:0]   ir_o;
    logic          halted, in_wait, branch_taken;
    logic          ctl_alu_en, ctl_shift_en, ctl_last;
    logic [3:0]    ctl_sel;
    logic [7:0]    acc_o;
    logic          flag_zero, flag_neg;

    logic [15:0] mem [0:(1<<AW)-1];
    int n_tests = 0;
    int n_fail  = 0;

    logic [AW-1:0] m_pc;
    logic [15:0]   m_ir;
    logic [7:0]    m_acc;
    int            m_cnt;
    bit            m_wait, m_halt;

    always #5 clk = ~clk;

    assign imem_rdata = mem[imem_addr];

    fetch_exec_ctrl #(.AW(AW), .START_ADDR(START), .INCR(AW'(1))) u_dut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .pc_o(pc_o), .ir_o(ir_o), .halted(halted), .in_wait(in_wait),
        .branch_taken(branch_taken), .ctl_alu_en(ctl_alu_en),
        .ctl_shift_en(ctl_shift_en), .ctl_last(ctl_last), .ctl_sel(ctl_sel),
        .acc_o(acc_o), .flag_zero(flag_zero), .flag_neg(flag_neg)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int cycles_of(input logic [3:0] op);
        if (op == 4'd2) return 3;
        if (op == 4'd3) return 4;
        return 1;
    endfunction

    task automatic m_load();
        m_ir  = mem[m_pc];
        m_pc  = m_pc + AW'(1);
        m_cnt = cycles_of(m_ir[15:12]) - 1;
    endtask

    task automatic m_init();
        m_pc   = START;
        m_load();
        m_acc  = 8'd0;
        m_wait = 1'b0;
        m_halt = 1'b0;
    endtask

    // reference model: one clock edge
    task automatic m_step();
        logic [AW-1:0] tgt;
        bit            take;
        tgt = m_pc + {{(AW-8){m_ir[7]}}, m_ir[7:0]};
        if (m_halt) begin
        end else if (m_wait) begin
            m_load();
            m_wait = 1'b0;
        end else if (m_cnt > 0) begin
            m_cnt--;
        end else begin
            take = (m_ir[15:12] == 4'd4) ||
                   (m_ir[15:12] == 4'd5 && m_acc == 8'd0) ||
                   (m_ir[15:12] == 4'd6 && m_acc[7]);
            if (m_ir[15:12] == 4'd15) begin
                m_halt = 1'b1;
            end else if (take) begin
                m_pc   = tgt;
                m_wait = 1'b1;
            end else begin
                if (m_ir[15:12] == 4'd1) m_acc = m_acc + m_ir[7:0];
                if (m_ir[15:12] == 4'd2) m_acc = {m_acc[6:0], 1'b0};
                m_load();
            end
        end
    endtask

    task automatic compare_all();
        bit exec;
        exec = !m_wait && !m_halt;
        check(pc_o == m_pc, "R2 R3 R4 R5 R6 R10", "pc", int'(pc_o), int'(m_pc));
        check(ir_o == m_ir, "R2 R5 R6 R8", "ir", int'(ir_o), int'(m_ir));
        check(acc_o == m_acc, "R9 R5", "acc", int'(acc_o), int'(m_acc));
        check(halted == m_halt, "R8", "halted", int'(halted), int'(m_halt));
        check(in_wait == m_wait, "R5", "in_wait", int'(in_wait), int'(m_wait));
        check(ctl_alu_en == (exec && m_ir[15:12] == 4'd1), "R7", "alu_en",
              int'(ctl_alu_en), int'(exec && m_ir[15:12] == 4'd1));
        check(ctl_shift_en == (exec && m_ir[15:12] == 4'd2), "R7", "shift_en",
              int'(ctl_shift_en), int'(exec && m_ir[15:12] == 4'd2));
        check(ctl_last == (exec && m_cnt == 0), "R6", "last",
              int'(ctl_last), int'(exec && m_cnt == 0));
        check(imem_addr == pc_o, "R2", "imem_addr", int'(imem_addr), int'(pc_o));
    endtask

    task automatic reset_phase();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        m_init();
        // R1: reset state
        check(pc_o == START + AW'(1), "R1", "pc", int'(pc_o), int'(START) + 1);
        check(ir_o == mem[START], "R1", "ir", int'(ir_o), int'(mem[START]));
        check(acc_o == 8'd0, "R1", "acc", int'(acc_o), 0);
        check(!halted && !in_wait, "R1", "state", int'({halted, in_wait}), 0);
        rst = 1'b0;
    endtask

    task automatic run_trace();
        int post = 0;
        for (int i = 0; i < 300 && post < 4; i++) begin
            @(negedge clk);
            m_step();
            compare_all();
            if (m_halt) post++;
        end
        check(m_halt && halted, "R8", "reached halt", int'(halted), 1);
    endtask

    initial begin
        for (int a = 0; a < (1 << AW); a++) mem[a] = 16'hF000;
        for (int i = 0; i < NPROG; i++) mem[START + AW'(i)] = PROG[i];

        reset_phase();
        run_trace();

        // R8: frozen for many cycles after halt
        begin
            logic [AW-1:0] pc_h;
            logic [15:0]   ir_h;
            pc_h = pc_o;
            ir_h = ir_o;
            repeat (6) @(negedge clk);
            check(pc_o == pc_h, "R8", "pc frozen", int'(pc_o), int'(pc_h));
            check(ir_o == ir_h, "R8", "ir frozen", int'(ir_o), int'(ir_h));
            check(halted, "R8", "still halted", int'(halted), 1);
        end

        // R1: reset from halt restarts the program; second full pass
        reset_phase();
        run_trace();

        // R5: fall-through words (ADDI 5, ADDI 7, ADDI 9) never touched acc
        check(acc_o == 8'd0, "R5", "final acc", int'(acc_o), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule